// File: doc/BRIEF.md
# Four-Channel Digital Downconverter with Averaging Decimator

This block converts four streams of signed ADC samples, arriving one per clock at the 80 MHz sample rate, into baseband I/Q pairs. Two numerically controlled oscillators, each a phase accumulator stepped by its own tuning word, address a sine table that is stored as a quarter wave. Each channel multiplies its sample by the cosine and the sine of one of these oscillators. A 2-bit mode input decides which oscillator each channel uses, so the four channels share two oscillators.

Each mixer product feeds a boxcar averager that sums 256 consecutive products. The averager then dumps the sum, scaled down by 256, into an output register and starts the next block. The delay this adds stays under 6.4 us. All channels dump on the same sample, so the I/Q outputs of the four channels describe the same time window.

A data-valid strobe marks each new set of results. A processor reads the held registers at its own much lower rate, about every 12.5 us. The results go to the processor directly: no filter stage follows the averager.

Top module: `iq_downconv`

## Requirements
- R1: While rstN is low, every iOut and qOut lane reads zero and dataValid is low.
- R2: dataValid is high for exactly one cycle per 256 samples. The first pulse appears after the 257th rising edge following reset release, and later pulses come every 256 cycles.
- R3: For each block of samples k = 256b .. 256b+255, where sample k is the value on adcData at the k-th rising edge after reset release (counted from 0), lane c of iOut holds floor(sum(x_c[k]*cos_c[k]) / 256) and lane c of qOut holds floor(sum(x_c[k]*sin_c[k]) / 256). Both are 24-bit two's complement, and lane c occupies bits [24c+23:24c].
- R4: Each oscillator has a 16-bit phase that is 0 for sample 0 and advances by its tuning word, modulo 2^16, for each sample. The table address p is phase[15:8]. With h = p mod 128, sin(p) = (2047*h*(128-h)) >> 12, negated when p >= 128. cos(p) = sin((p+64) mod 256).
- R5: mapMode selects the oscillator per channel. 0 puts all channels on oscillator A. 1 puts channels 0 and 1 on A and channels 2 and 3 on B. 2 puts even channels on A and odd channels on B. 3 puts all channels on B. adcData lane c occupies bits [12c+11:12c].
- R6: All channels' I/Q results for a block become visible in the same cycle, the cycle in which dataValid is high.
- R7: Between dataValid pulses, iOut and qOut hold their values.
- R8: Full-scale input (-2048 on every sample, with the cosine at +2047) gives the exact result -4192256 with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ftwA | input | 16 | Phase step per sample of oscillator A |
| ftwB | input | 16 | Phase step per sample of oscillator B |
| mapMode | input | 2 | Channel-to-oscillator assignment mode |
| adcData | input | 48 | Four signed 12-bit samples |
| iOut | output | 96 | Four signed 24-bit in-phase results |
| qOut | output | 96 | Four signed 24-bit quadrature results |
| dataValid | output | 1 | One-cycle strobe marking new results |

## Verification
The hardest condition to reach is the largest possible sum at the moment of the dump. Random samples almost never line up with the oscillator so that all 256 products share the same extreme sign, so this corner needs directed stimulus. The stimulus therefore sets a zero tuning word, which holds the cosine at its positive peak, and drives -2048 on every lane for the whole block. Random blocks run with tuning words that wrap the phase several times per block, including a step of half a turn and one count below a full turn. Every mapping mode is run with distinct tuning words on the two oscillators, so that a wrong assignment changes the results.

// File: rtl/iq_downconv_pkg.sv
package iq_downconv_pkg;
  // Strobes the control sequencer hands to the datapath each cycle.
  typedef struct packed {
    logic accEn;  // product register holds a fresh product to accumulate
    logic dump;   // that product closes the current averaging block
  } strobe_t;

  typedef enum logic [1:0] {
    MAP_ALL_A = 2'd0,
    MAP_SPLIT = 2'd1,
    MAP_EVEN_ODD = 2'd2,
    MAP_ALL_B = 2'd3
  } map_mode_e;
endpackage

// File: rtl/iq_downconv_lo.sv
module iq_downconv_lo #(
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 8,
  parameter int LO_W    = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PHASE_W-1:0]        ftw,
  output logic signed [LO_W-1:0]    sinV,
  output logic signed [LO_W-1:0]    cosV
);
  localparam int HALF  = 2 ** (LUT_AW - 1);
  localparam int QTR   = 2 ** (LUT_AW - 2);
  localparam int AMP   = 2 ** (LO_W - 1) - 1;
  localparam int SCALE = 2 * (LUT_AW - 2);

  logic [PHASE_W-1:0] phase;
  logic [LUT_AW-1:0]  addrSin;
  logic [LUT_AW-1:0]  addrCos;

  // Quarter-wave table: the index folds into the first quarter, and the
  // sign comes from the top address bit.
  function automatic logic signed [LO_W-1:0] waveAt(input logic [LUT_AW-1:0] a);
    int half;
    int q;
    int mag;
    half = int'(a[LUT_AW-2:0]);
    q    = (half > QTR) ? (HALF - half) : half;
    mag  = (AMP * q * (HALF - q)) >>> SCALE;
    if (a[LUT_AW-1]) return LO_W'(-mag);
    else             return LO_W'(mag);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + ftw;
  end

  assign addrSin = phase[PHASE_W-1 -: LUT_AW];
  assign addrCos = addrSin + LUT_AW'(QTR);

  always_comb begin
    sinV = waveAt(addrSin);
    cosV = waveAt(addrCos);
  end
endmodule

// File: rtl/iq_downconv_ctrl.sv
module iq_downconv_ctrl
  import iq_downconv_pkg::*;
#(
  parameter int DEC = 256
) (
  input  logic    clk,
  input  logic    rstN,
  output strobe_t strb,
  output logic    dataValid
);
  localparam int CNT_W = $clog2(DEC);

  logic             prodValid;
  logic [CNT_W-1:0] blkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodValid <= 1'b0;
      blkCnt    <= '0;
      dataValid <= 1'b0;
    end else begin
      prodValid <= 1'b1;
      dataValid <= strb.dump;
      if (strb.accEn) blkCnt <= blkCnt + 1'b1;
    end
  end

  always_comb begin
    strb.accEn = prodValid;
    strb.dump  = prodValid && (blkCnt == CNT_W'(DEC - 1));
  end
endmodule

// File: rtl/iq_downconv_dp.sv
module iq_downconv_dp
  import iq_downconv_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int ADC_W   = 12,
  parameter int LO_W    = 12,
  parameter int DEC     = 256,
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strb,
  input  logic [PHASE_W-1:0]               ftwA,
  input  logic [PHASE_W-1:0]               ftwB,
  input  logic [1:0]                       mapMode,
  input  logic [NCH*ADC_W-1:0]             adcData,
  output logic [NCH*(ADC_W+LO_W)-1:0]      iOut,
  output logic [NCH*(ADC_W+LO_W)-1:0]      qOut
);
  localparam int PROD_W = ADC_W + LO_W;
  localparam int SHIFT  = $clog2(DEC);
  localparam int ACC_W  = PROD_W + SHIFT;
  localparam int OUT_W  = ACC_W - SHIFT;

  logic signed [LO_W-1:0] sinA, cosA, sinB, cosB;

  iq_downconv_lo #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LO_W(LO_W)) u_loA (
    .clk(clk), .rstN(rstN), .ftw(ftwA), .sinV(sinA), .cosV(cosA)
  );
  iq_downconv_lo #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LO_W(LO_W)) u_loB (
    .clk(clk), .rstN(rstN), .ftw(ftwB), .sinV(sinB), .cosV(cosB)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic                     useB;
    logic signed [ADC_W-1:0]  sample;
    logic signed [LO_W-1:0]   loCos, loSin;
    logic signed [PROD_W-1:0] prodI, prodQ;
    logic signed [ACC_W-1:0]  accI, accQ;
    logic signed [ACC_W-1:0]  sumI, sumQ;
    logic [OUT_W-1:0]         resI, resQ;

    always_comb begin
      unique case (map_mode_e'(mapMode))
        MAP_ALL_A:    useB = 1'b0;
        MAP_SPLIT:    useB = (c >= NCH / 2);
        MAP_EVEN_ODD: useB = (c % 2 == 1);
        default:      useB = 1'b1;
      endcase
    end

    assign sample = adcData[c*ADC_W +: ADC_W];
    assign loCos  = useB ? cosB : cosA;
    assign loSin  = useB ? sinB : sinA;
    assign sumI   = accI + ACC_W'(prodI);
    assign sumQ   = accQ + ACC_W'(prodQ);

    // Mixer register: one product pair per sample.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prodI <= '0;
        prodQ <= '0;
      end else begin
        prodI <= sample * loCos;
        prodQ <= sample * loSin;
      end
    end

    // Boxcar integrate-and-dump; the dump drops the low SHIFT bits.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accI <= '0;
        accQ <= '0;
        resI <= '0;
        resQ <= '0;
      end else if (strb.accEn) begin
        if (strb.dump) begin
          accI <= '0;
          accQ <= '0;
          resI <= sumI[ACC_W-1:SHIFT];
          resQ <= sumQ[ACC_W-1:SHIFT];
        end else begin
          accI <= sumI;
          accQ <= sumQ;
        end
      end
    end

    assign iOut[c*OUT_W +: OUT_W] = resI;
    assign qOut[c*OUT_W +: OUT_W] = resQ;
  end
endmodule

// File: rtl/iq_downconv.sv
module iq_downconv
  import iq_downconv_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int ADC_W   = 12,
  parameter int LO_W    = 12,
  parameter int DEC     = 256,
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PHASE_W-1:0]          ftwA,
  input  logic [PHASE_W-1:0]          ftwB,
  input  logic [1:0]                  mapMode,
  input  logic [NCH*ADC_W-1:0]        adcData,
  output logic [NCH*(ADC_W+LO_W)-1:0] iOut,
  output logic [NCH*(ADC_W+LO_W)-1:0] qOut,
  output logic                        dataValid
);
  strobe_t strb;

  iq_downconv_ctrl #(.DEC(DEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .strb(strb), .dataValid(dataValid)
  );

  iq_downconv_dp #(
    .NCH(NCH), .ADC_W(ADC_W), .LO_W(LO_W), .DEC(DEC),
    .PHASE_W(PHASE_W), .LUT_AW(LUT_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ftwA(ftwA), .ftwB(ftwB),
    .mapMode(mapMode), .adcData(adcData), .iOut(iOut), .qOut(qOut)
  );
endmodule

// File: rtl/iq_downconv_chk.sv
module iq_downconv_chk #(
  parameter int NCH   = 4,
  parameter int OUT_W = 24,
  parameter int DEC   = 256
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NCH*OUT_W-1:0] iOut,
  input logic [NCH*OUT_W-1:0] qOut,
  input logic                 dataValid
);
  localparam int GAP_W = $clog2(DEC) + 2;

  logic [GAP_W-1:0] gap;
  logic             seenValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap       <= '0;
      seenValid <= 1'b0;
    end else begin
      gap <= dataValid ? GAP_W'(1) : gap + 1'b1;
      if (dataValid) seenValid <= 1'b1;
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |-> (iOut == '0 && qOut == '0 && !dataValid));

  // R2
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R2
  a_r2_first_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !seenValid) |-> gap == GAP_W'(DEC + 1));

  // R2
  a_r2_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && seenValid) |-> gap == GAP_W'(DEC));

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> (dataValid || ($stable(iOut) && $stable(qOut))));
endmodule

bind iq_downconv iq_downconv_chk #(
  .NCH(NCH), .OUT_W(ADC_W + LO_W), .DEC(DEC)
) u_chk (
  .clk(clk), .rstN(rstN), .iOut(iOut), .qOut(qOut), .dataValid(dataValid)
);

// File: tb/iq_downconv_tb.sv
module iq_downconv_tb;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int OW  = 24;
  localparam int DEC = 256;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [15:0]         ftwA = '0;
  logic [15:0]         ftwB = '0;
  logic [1:0]          mapMode = '0;
  logic [NCH*AW-1:0]   adcData = '0;
  logic [NCH*OW-1:0]   iOut;
  logic [NCH*OW-1:0]   qOut;
  logic                dataValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  iq_downconv u_dut (
    .clk(clk), .rstN(rstN), .ftwA(ftwA), .ftwB(ftwB), .mapMode(mapMode),
    .adcData(adcData), .iOut(iOut), .qOut(qOut), .dataValid(dataValid)
  );

  function automatic longint sinRef(input int p);
    int h;
    longint m;
    h = p % 128;
    m = (2047 * h * (128 - h)) >>> 12;
    return (p >= 128) ? -m : m;
  endfunction

  function automatic longint cosRef(input int p);
    return sinRef((p + 64) % 256);
  endfunction

  function automatic bit usesB(input int mode, input int ch);
    case (mode)
      0: return 1'b0;
      1: return ch >= 2;
      2: return (ch % 2) == 1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic longint lane(input logic [NCH*OW-1:0] v, input int c);
    logic signed [OW-1:0] x;
    x = v[c*OW +: OW];
    return longint'(x);
  endfunction

  // kind: 0 random full range, 1 all -2048, 2 constant +2047, 3 small alternating
  task automatic runSeg(input string req, input logic [15:0] fa, input logic [15:0] fb,
                        input int mode, input int kind, input int nBlk);
    longint sumI[NCH], sumQ[NCH], expI[NCH], expQ[NCH];
    int phA, phB;
    rstN = 1'b0;
    ftwA = fa;
    ftwB = fb;
    mapMode = 2'(mode);
    adcData = '0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check("R1", "iOut in reset", lane(iOut, c), 0);
      check("R1", "qOut in reset", lane(qOut, c), 0);
      sumI[c] = 0; sumQ[c] = 0; expI[c] = 0; expQ[c] = 0;
    end
    check("R1", "dataValid in reset", longint'(dataValid), 0);
    phA = 0;
    phB = 0;
    for (int k = 0; k <= nBlk * DEC + 1; k++) begin
      @(negedge clk);
      if (k == 0) rstN = 1'b1;
      if (k >= DEC + 1 && ((k - 1) % DEC) == 0) begin
        check("R2", "dataValid at block end", longint'(dataValid), 1);
        for (int c = 0; c < NCH; c++) begin
          check(req, $sformatf("R3 R6 iOut ch%0d", c), lane(iOut, c), expI[c]);
          check(req, $sformatf("R3 R6 qOut ch%0d", c), lane(qOut, c), expQ[c]);
        end
      end else if (k >= DEC + 1 && ((k - 1) % DEC) == DEC / 2) begin
        check("R2", "dataValid mid block", longint'(dataValid), 0);
        for (int c = 0; c < NCH; c++)
          check("R7", $sformatf("iOut held ch%0d", c), lane(iOut, c), expI[c]);
      end else if (k == DEC) begin
        check("R2", "no early pulse", longint'(dataValid), 0);
      end
      if (k < nBlk * DEC) begin
        for (int c = 0; c < NCH; c++) begin
          int v;
          int p;
          case (kind)
            0: v = int'($urandom_range(4095)) - 2048;
            1: v = -2048;
            2: v = 2047;
            default: v = ((k + c) % 2 == 0) ? int'($urandom_range(300)) : -int'($urandom_range(300));
          endcase
          adcData[c*AW +: AW] = AW'(v);
          p = usesB(mode, c) ? (phB >> 8) : (phA >> 8);
          sumI[c] += longint'(v) * cosRef(p);
          sumQ[c] += longint'(v) * sinRef(p);
        end
        phA = (phA + int'(fa)) & 16'hFFFF;
        phB = (phB + int'(fb)) & 16'hFFFF;
        if ((k % DEC) == DEC - 1) begin
          for (int c = 0; c < NCH; c++) begin
            expI[c] = sumI[c] >>> 8;
            expQ[c] = sumQ[c] >>> 8;
            sumI[c] = 0;
            sumQ[c] = 0;
          end
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1D0C_5EED));
    runSeg("R4", 16'h0123, 16'h0A00, 0, 0, 3);
    runSeg("R5", 16'h0340, 16'h1100, 1, 0, 2);
    runSeg("R5", 16'h2000, 16'h0155, 2, 3, 2);
    runSeg("R5", 16'h0777, 16'h0B0B, 3, 0, 2);
    runSeg("R8", 16'h0000, 16'h0000, 0, 1, 2);
    check("R8", "full-scale iOut", lane(iOut, 0), -64'sd4192256);
    runSeg("R4", 16'h8000, 16'hFFFF, 2, 0, 2);
    runSeg("R3", 16'h4000, 16'h0001, 1, 2, 2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule